// File: doc/BRIEF.md
# Page Write Buffer Controller

This block sits between the command decoder of a serial memory and its storage array. Once a write command is decoded, the block takes a start address. It then gathers the data bytes that follow into a buffer that holds exactly one page. The column pointer advances inside that page and wraps back to the page start. It never carries into the next page. When the host releases chip-select, the decoder reports whether the release fell on a whole-byte boundary. Only an aligned release, after at least one data byte and with the write enable latch set, commits the buffered bytes. The commit runs as a self-timed cycle of a fixed number of clock ticks.

During the cycle the block walks the page once and drives the array write port for each column that received a byte. Columns that received no byte are left as they were. The busy output is high for the whole cycle, and the block refuses array reads while it is busy. When the count expires, busy falls, a one-cycle done pulse is issued and the write enable latch is cleared. The array is a synchronous RAM inside the block. Its write port is also visible at the outputs.

Top module: `page_write_ctrl`

## Requirements
- R1: After reset, busy, done, mem_we, wel, rd_valid and rd_refused are all low.
- R2: A release with release_aligned=1, after one or more accepted bytes and with wel=1, raises busy on the next cycle. Byte k of the session is then stored at array address {start_addr upper bits, (start_addr[PAGE_W-1:0]+k) mod 2^PAGE_W}.
- R3: The column wraps from 2^PAGE_W-1 to 0 within the same page, and the upper address bits stay fixed. A later byte that lands on an already filled column replaces the earlier one.
- R4: Page columns that received no byte in the committed session keep their previous array contents.
- R5: A release with release_aligned=0, or an aligned release with no byte accepted, abandons the session. Busy stays low and the array is unchanged.
- R6: A wel_set pulse while idle sets wel on the next cycle. If wel=0 at the release, no commit happens and the array is unchanged.
- R7: Busy stays high for exactly WRITE_TICKS cycles. done is high for exactly one cycle, the first cycle with busy low, and wel is already low in that cycle.
- R8: An rd_en while busy gives rd_refused=1 and rd_valid=0 one cycle later. An rd_en while idle gives rd_valid=1 one cycle later, with rd_data equal to the array byte at rd_addr.
- R9: cmd_start, byte_valid and cs_release that arrive while busy start no session and have no effect on the array. A later release, arriving when no session is open, does not raise busy.
- R10: mem_we is high only while busy, and every address it writes lies in the committed page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wel_set | input | 1 | Pulse that sets the write enable latch |
| cmd_start | input | 1 | Opens a write session at start_addr |
| start_addr | input | ADDR_W | First byte address of the session |
| byte_valid | input | 1 | One data byte is present on byte_data |
| byte_data | input | DATA_W | Data byte |
| cs_release | input | 1 | Chip-select released, closes the session |
| release_aligned | input | 1 | Release came right after bit 0 of a whole byte |
| rd_en | input | 1 | Array read request |
| rd_addr | input | ADDR_W | Array read address |
| wel | output | 1 | Write enable latch state |
| busy | output | 1 | Self-timed write cycle running |
| done | output | 1 | One-cycle pulse when the cycle ends |
| mem_we | output | 1 | Array write enable |
| mem_addr | output | ADDR_W | Array write address |
| mem_wdata | output | DATA_W | Array write data |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | DATA_W | Read data |
| rd_refused | output | 1 | Read request turned down because busy |

## Verification
A column pointer that slips, or a lost valid flag, shows up as a wrong or stale byte when the page is read back right after done. This takes about WRITE_TICKS cycles after the release. A wrong commit decision is visible on busy one cycle after the release. An error in the tick counter moves the falling edge of busy and the done pulse away from the expected cycle, and the wel flag clears at the same moment. The busy-length check and the read probe inside the cycle make both of these errors observable in the first session.

// File: rtl/pwb_pkg.sv
`timescale 1ns/1ps
package pwb_pkg;
  // Next column inside a page of 2**bits bytes: wraps, never carries.
  function automatic logic [31:0] col_step(input logic [31:0] col, input int unsigned bits);
    return (col + 32'd1) & ((32'd1 << bits) - 32'd1);
  endfunction

  // Full array address from page number and column.
  function automatic logic [31:0] page_join(input logic [31:0] page, input logic [31:0] col,
                                            input int unsigned bits);
    return (page << bits) | col;
  endfunction
endpackage

// File: rtl/pwb_page_buffer.sv
`timescale 1ns/1ps
module pwb_page_buffer #(
  parameter int PAGE_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              wr_en,
  input  logic [PAGE_W-1:0] wr_col,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [PAGE_W-1:0] rd_col,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_filled
);
  localparam int SLOTS = 1 << PAGE_W;

  logic [DATA_W-1:0] slot_q [SLOTS];
  logic [SLOTS-1:0]  filled_q;

  always_ff @(posedge clk) begin
    if (wr_en) slot_q[wr_col] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      filled_q <= '0;
    end else if (clear) begin
      filled_q <= '0;
    end else if (wr_en) begin
      filled_q[wr_col] <= 1'b1;
    end
  end

  assign rd_data   = slot_q[rd_col];
  assign rd_filled = filled_q[rd_col];
endmodule

// File: rtl/pwb_cycle_timer.sv
`timescale 1ns/1ps
module pwb_cycle_timer #(
  parameter int TICKS = 300,
  localparam int CNT_W = $clog2(TICKS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output logic             busy,
  output logic [CNT_W-1:0] tick,
  output logic             finishing,
  output logic             done
);
  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;
  logic             done_q;

  assign finishing = busy_q && (cnt_q == CNT_W'(TICKS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (busy_q) begin
        if (finishing) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
          cnt_q  <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end else if (start) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
      end
    end
  end

  assign busy = busy_q;
  assign tick = cnt_q;
  assign done = done_q;
endmodule

// File: rtl/pwb_array_ram.sv
`timescale 1ns/1ps
module pwb_array_ram #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] cell_q [DEPTH];
  logic [DATA_W-1:0] rdata_q;

  always_ff @(posedge clk) begin
    if (we) cell_q[waddr] <= wdata;
    if (re) rdata_q <= cell_q[raddr];
  end

  assign rdata = rdata_q;
endmodule

// File: rtl/page_write_ctrl.sv
`timescale 1ns/1ps
module page_write_ctrl #(
  parameter int ADDR_W      = 11,
  parameter int PAGE_W      = 8,
  parameter int DATA_W      = 8,
  parameter int WRITE_TICKS = 300
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wel_set,
  input  logic              cmd_start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic              byte_valid,
  input  logic [DATA_W-1:0] byte_data,
  input  logic              cs_release,
  input  logic              release_aligned,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              wel,
  output logic              busy,
  output logic              done,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_refused
);
  import pwb_pkg::*;

  localparam int PG_W       = ADDR_W - PAGE_W;
  localparam int PAGE_BYTES = 1 << PAGE_W;
  localparam int CNT_W      = $clog2(WRITE_TICKS + 1);

  // session state
  logic              collect_q;
  logic              has_byte_q;
  logic [PG_W-1:0]   page_q;
  logic [PAGE_W-1:0] col_q;
  logic              wel_q;
  logic              rd_valid_q;
  logic              rd_refused_q;

  // named internal events
  logic ev_accept;
  logic ev_take;
  logic ev_release;
  logic ev_commit;
  logic ev_abandon;

  // timer and buffer wires
  logic              tmr_busy;
  logic              tmr_finishing;
  logic              tmr_done;
  logic [CNT_W-1:0]  tmr_tick;
  logic [PAGE_W-1:0] walk_col;
  logic              walk_in_page;
  logic [DATA_W-1:0] slot_data;
  logic              slot_filled;
  logic [PAGE_W-1:0] col_next;

  assign ev_accept  = cmd_start && !tmr_busy;
  assign ev_take    = byte_valid && collect_q && !tmr_busy;
  assign ev_release = cs_release && collect_q && !tmr_busy;
  assign ev_commit  = ev_release && release_aligned && has_byte_q && wel_q;
  assign ev_abandon = ev_release && !ev_commit;

  assign col_next = PAGE_W'(col_step(32'(col_q), PAGE_W));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      collect_q  <= 1'b0;
      has_byte_q <= 1'b0;
      page_q     <= '0;
      col_q      <= '0;
    end else if (ev_accept) begin
      collect_q  <= 1'b1;
      has_byte_q <= 1'b0;
      page_q     <= start_addr[ADDR_W-1:PAGE_W];
      col_q      <= start_addr[PAGE_W-1:0];
    end else begin
      if (ev_take) begin
        col_q      <= col_next;
        has_byte_q <= 1'b1;
      end
      if (ev_release) collect_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wel_q <= 1'b0;
    end else if (tmr_finishing) begin
      wel_q <= 1'b0;
    end else if (wel_set && !tmr_busy) begin
      wel_q <= 1'b1;
    end
  end

  pwb_page_buffer #(.PAGE_W(PAGE_W), .DATA_W(DATA_W)) u_buffer (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (ev_accept),
    .wr_en     (ev_take),
    .wr_col    (col_q),
    .wr_data   (byte_data),
    .rd_col    (walk_col),
    .rd_data   (slot_data),
    .rd_filled (slot_filled)
  );

  pwb_cycle_timer #(.TICKS(WRITE_TICKS)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (ev_commit),
    .busy      (tmr_busy),
    .tick      (tmr_tick),
    .finishing (tmr_finishing),
    .done      (tmr_done)
  );

  // The first PAGE_BYTES ticks of the cycle walk the page once.
  assign walk_col     = tmr_tick[PAGE_W-1:0];
  assign walk_in_page = tmr_tick < CNT_W'(PAGE_BYTES);
  assign mem_we       = tmr_busy && walk_in_page && slot_filled;
  assign mem_addr     = ADDR_W'(page_join(32'(page_q), 32'(walk_col), PAGE_W));
  assign mem_wdata    = slot_data;

  pwb_array_ram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
    .clk   (clk),
    .we    (mem_we),
    .waddr (mem_addr),
    .wdata (mem_wdata),
    .re    (rd_en && !tmr_busy),
    .raddr (rd_addr),
    .rdata (rd_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid_q   <= 1'b0;
      rd_refused_q <= 1'b0;
    end else begin
      rd_valid_q   <= rd_en && !tmr_busy;
      rd_refused_q <= rd_en && tmr_busy;
    end
  end

  assign wel        = wel_q;
  assign busy       = tmr_busy;
  assign done       = tmr_done;
  assign rd_valid   = rd_valid_q;
  assign rd_refused = rd_refused_q;
endmodule

// File: rtl/pwb_checker.sv
`timescale 1ns/1ps
module pwb_checker #(
  parameter int PG_W  = 3,
  parameter int TICKS = 300
) (
  input logic            clk,
  input logic            rst_n,
  input logic            busy,
  input logic            done,
  input logic            wel,
  input logic            mem_we,
  input logic [PG_W-1:0] page_bits,
  input logic            rd_en,
  input logic            rd_valid,
  input logic            rd_refused,
  input logic            ev_commit,
  input logic            ev_abandon
);
  logic [31:0] busy_len_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busy_len_q <= '0;
    else        busy_len_q <= busy ? busy_len_q + 32'd1 : 32'd0;
  end

  AST_COMMIT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    ev_commit |=> busy); // R2
  AST_ABANDON_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    ev_abandon |=> !busy); // R5
  AST_BUSY_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> busy_len_q == 32'(TICKS)); // R7
  AST_DONE_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy))); // R7
  AST_WEL_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !wel); // R7
  AST_REFUSE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    rd_refused |-> ($past(busy) && $past(rd_en) && !rd_valid)); // R8
  AST_PAGE_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && $past(mem_we)) |-> $stable(page_bits)); // R10
  AST_WE_IN_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> busy); // R10
endmodule

bind page_write_ctrl pwb_checker #(.PG_W(ADDR_W - PAGE_W), .TICKS(WRITE_TICKS)) u_pwb_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .busy       (busy),
  .done       (done),
  .wel        (wel),
  .mem_we     (mem_we),
  .page_bits  (mem_addr[ADDR_W-1:PAGE_W]),
  .rd_en      (rd_en),
  .rd_valid   (rd_valid),
  .rd_refused (rd_refused),
  .ev_commit  (ev_commit),
  .ev_abandon (ev_abandon)
);

// File: tb/test_page_write_ctrl.sv
`timescale 1ns/1ps
module test_page_write_ctrl;
  localparam int AW = 11, PW = 8, DW = 8, TICKS = 300;
  localparam int NVEC = 6;
  // {start addr[10:0], byte count[8:0], seed[7:0], aligned}
  localparam logic [28:0] VECS [NVEC] = '{
    {11'h000, 9'd256, 8'h11, 1'b1},  // full page 0
    {11'h100, 9'd256, 8'h40, 1'b1},  // full page 1
    {11'h010, 9'd4,   8'hA0, 1'b1},  // partial, rest kept
    {11'h1F0, 9'd40,  8'h33, 1'b1},  // wraps inside page 1
    {11'h020, 9'd5,   8'h77, 1'b0},  // misaligned release
    {11'h0FE, 9'd300, 8'h05, 1'b1}   // overruns, overwrites
  };

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, wel_set, cmd_start, byte_valid, cs_release, release_aligned, rd_en;
  logic [AW-1:0] start_addr, rd_addr;
  logic [DW-1:0] byte_data;
  logic wel, busy, done, mem_we, rd_valid, rd_refused;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata, rd_data;

  page_write_ctrl #(.ADDR_W(AW), .PAGE_W(PW), .DATA_W(DW), .WRITE_TICKS(TICKS)) i_page_write_ctrl (
    .clk(clk), .rst_n(rst_n), .wel_set(wel_set), .cmd_start(cmd_start), .start_addr(start_addr),
    .byte_valid(byte_valid), .byte_data(byte_data), .cs_release(cs_release),
    .release_aligned(release_aligned), .rd_en(rd_en), .rd_addr(rd_addr), .wel(wel), .busy(busy),
    .done(done), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .rd_refused(rd_refused));

  int n_chk = 0, n_bad = 0, bad_we = 0;
  bit finished = 1'b0;
  logic [PW-1:0] model [1 << AW];
  bit            mdef  [1 << AW];
  logic [AW-PW-1:0] exp_page = '0;

  function automatic logic [7:0] dat(input logic [7:0] seed, input int k);
    return 8'(int'(seed) + k * 7);
  endfunction

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "WATCHDOG", "run did not end", 0, 1);
    finish_run();
  end

  // R10: every array write falls in the committed page, only while busy
  always @(negedge clk)
    if (rst_n && mem_we && (mem_addr[AW-1:PW] != exp_page || !busy)) bad_we++;

  task automatic model_apply(input logic [AW-1:0] a, input int n, input logic [7:0] seed);
    for (int k = 0; k < n; k++) begin
      int ad = (int'(a) & ~((1 << PW) - 1)) | ((int'(a) + k) & ((1 << PW) - 1));
      model[ad] = dat(seed, k);
      mdef[ad]  = 1'b1;
    end
  endtask

  task automatic session(input logic [AW-1:0] a, input int n, input logic [7:0] seed,
                         input bit aligned, input bit set_wel);
    if (set_wel) begin
      wel_set = 1'b1; @(negedge clk); wel_set = 1'b0;
    end
    cmd_start = 1'b1; start_addr = a; @(negedge clk); cmd_start = 1'b0;
    for (int k = 0; k < n; k++) begin
      byte_valid = 1'b1; byte_data = dat(seed, k); @(negedge clk);
    end
    byte_valid = 1'b0;
    cs_release = 1'b1; release_aligned = aligned; @(negedge clk);
    cs_release = 1'b0; release_aligned = 1'b0;
  endtask

  task automatic wait_commit(input int elapsed, input int probe_at);
    int cnt = elapsed;
    while (busy && cnt < 2 * TICKS) begin
      cnt++;
      if (cnt == probe_at) begin rd_en = 1'b1; rd_addr = '0; end
      if (cnt == probe_at + 1) begin
        rd_en = 1'b0;
        check(rd_refused && !rd_valid, "R8", "read during busy refused", {rd_refused, rd_valid}, 2);
      end
      @(negedge clk);
    end
    check(cnt == TICKS, "R7", "busy length", cnt, TICKS);
    check(done === 1'b1, "R7", "done as busy falls", done, 1);
    check(wel === 1'b0, "R7", "latch cleared at done", wel, 0);
    @(negedge clk);
    check(done === 1'b0, "R7", "done one cycle", done, 0);
    check(bad_we == 0, "R10", "writes in committed page", bad_we, 0);
    bad_we = 0;
  endtask

  task automatic check_page(input int page, input string req);
    int errs = 0, first = -1, act = 0, expv = 0, miss = 0;
    for (int c = 0; c < (1 << PW); c++) begin
      int ad = page * (1 << PW) + c;
      rd_en = 1'b1; rd_addr = AW'(ad); @(negedge clk); rd_en = 1'b0;
      if (!rd_valid) miss++;
      if (mdef[ad] && rd_data !== model[ad]) begin
        errs++;
        if (first < 0) begin first = ad; act = int'(rd_data); expv = int'(model[ad]); end
      end
    end
    check(miss == 0, "R8", "idle read valid", miss, 0);
    check(errs == 0, req, $sformatf("page %0d contents (addr %0d)", page, first), act, expv);
  endtask

  initial begin
    rst_n = 1'b0; wel_set = 0; cmd_start = 0; byte_valid = 0; cs_release = 0;
    release_aligned = 0; rd_en = 0; start_addr = '0; rd_addr = '0; byte_data = '0;
    for (int i = 0; i < (1 << AW); i++) mdef[i] = 1'b0;
    repeat (3) @(negedge clk);
    check({busy, done, mem_we, wel, rd_valid, rd_refused} == 6'b0, "R1", "reset outputs",
          {busy, done, mem_we, wel, rd_valid, rd_refused}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // vector table: one write session each
    for (int v = 0; v < NVEC; v++) begin
      logic [AW-1:0] a   = VECS[v][28:18];
      int            n   = int'(VECS[v][17:9]);
      logic [7:0]    sd  = VECS[v][8:1];
      bit            al  = VECS[v][0];
      string         tag;
      tag = !al ? "R5" : (n > 256 || (int'(a[PW-1:0]) + n) > 256) ? "R3" : (n < 256) ? "R4" : "R2";
      exp_page = a[AW-1:PW];
      session(a, n, sd, al, 1'b1);
      check(busy === al, tag, "commit decision", busy, al);
      if (al) begin
        wait_commit(0, 5);
        model_apply(a, n, sd);
      end else begin
        check(wel === 1'b1, "R5", "latch kept after abandon", wel, 1);
      end
      check_page(int'(a[AW-1:PW]), tag);
    end

    // R6: latch clear, no commit
    check(wel === 1'b0, "R6", "latch low before test", wel, 0);
    session(11'h030, 3, 8'hEE, 1'b1, 1'b0);
    check(busy === 1'b0, "R6", "no commit without latch", busy, 0);
    check_page(0, "R6");
    // R6: latch sets
    wel_set = 1'b1; @(negedge clk); wel_set = 1'b0;
    check(wel === 1'b1, "R6", "latch set", wel, 1);
    // R5: aligned release with zero bytes
    session(11'h040, 0, 8'h00, 1'b1, 1'b0);
    check(busy === 1'b0, "R5", "no commit with zero bytes", busy, 0);

    // R9: traffic during busy is ignored
    exp_page = 3'd1;
    session(11'h105, 2, 8'hC3, 1'b1, 1'b0);
    check(busy === 1'b1, "R2", "commit started", busy, 1);
    cmd_start = 1'b1; start_addr = 11'h000; @(negedge clk); cmd_start = 1'b0;
    for (int k = 0; k < 3; k++) begin byte_valid = 1'b1; byte_data = 8'h5A; @(negedge clk); end
    byte_valid = 1'b0;
    cs_release = 1'b1; release_aligned = 1'b1; @(negedge clk);
    cs_release = 1'b0; release_aligned = 1'b0;
    wait_commit(5, 10);
    model_apply(11'h105, 2, 8'hC3);
    wel_set = 1'b1; @(negedge clk); wel_set = 1'b0;
    cs_release = 1'b1; release_aligned = 1'b1; @(negedge clk);
    cs_release = 1'b0; release_aligned = 1'b0;
    check(busy === 1'b0, "R9", "stray release without session", busy, 0);
    check_page(0, "R9");
    check_page(1, "R2");

    finish_run();
  end
endmodule